// File: doc/BRIEF.md
# UART Modem Handshake Controller

This block runs the handshake lines of a serial port that acts as the terminal end of a link. It drives the two outgoing lines, DTR and RTS, which are active low. It watches the four incoming lines, CTS, DSR, DCD and RI, which are also active low. Each incoming line passes through a synchronizer and an edge detector. A level change in either direction sets a sticky flag for that line. Any flag whose mask bit is set raises the interrupt.

The block also gates the enable of an attached transmitter on CTS. A character that is already being shifted out is always finished before the enable drops. Software reaches the block through a small register bus with a two-bit address and a write strobe. Reads are combinational, and a read strobe marks a status read. The handshake logic works only while the mode field selects modem operation (code 3). In every other mode the outgoing lines stay high.

Top module: `modem_ctrl`

## Requirements
- R1: After reset the outputs are dtr_out=1, rts_out=1, tx_en=0 and irq=0. The register reads are: mode (address 1) = 0, mask (address 3) = 0, and status (address 2) = 8'hF0, which means all four lines read as high and no flags are set.
- R2: While the mode field (address 1, bits 1:0) is not 3, dtr_out and rts_out stay high. Changes on the incoming lines set no flag, including the lines' past changes when modem mode is entered later.
- R3: A write to the command register (address 0) sets DTR as follows. Bit 0 drives DTR low. Bit 1 drives DTR high. When both bits are written together, bit 1 wins and DTR goes high. The level is held until the next command. While the mode field is 3, dtr_out shows this held level.
- R4: A command write with bit 2 turns the software transmit enable on, and bit 3 turns it off. When both are written together, off wins. rts_out is low exactly when the mode field is 3 and the software enable is on.
- R5: The status register has four flag bits: bit 0 CTS, bit 1 DSR, bit 2 DCD and bit 3 RI. In modem mode, a level change in either direction on a line sets that line's flag. The flag is set on the third rising clock edge after the input changes. Status bits 7:4 show the synchronized levels of the lines, in the same order.
- R6: A status read (reg_rd with address 2) clears all four flags at the clock edge that ends the read. A change detected at that same edge keeps its flag set.
- R7: irq is the OR over the four lines of each flag ANDed with its mask bit. The mask register is at address 3, bits 3:0, and bit i enables flag i.
- R8: In modem mode, tx_en is the software enable gated by CTS being low. When CTS goes high while tx_busy is high, tx_en stays high until tx_busy falls. tx_en then drops on the next clock edge.
- R9: The mode register reads back its stored field. Outside modem mode, tx_en follows the software enable without regard to CTS.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 2 | Register address: 0 command, 1 mode, 2 status, 3 mask |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe (only a status read has a side effect) |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Combinational read data for reg_addr |
| cts_in | input | 1 | Clear-to-send line, active low, asynchronous |
| dsr_in | input | 1 | Data-set-ready line, active low, asynchronous |
| dcd_in | input | 1 | Carrier-detect line, active low, asynchronous |
| ri_in | input | 1 | Ring line, active low, asynchronous |
| dtr_out | output | 1 | Terminal-ready line, active low |
| rts_out | output | 1 | Request-to-send line, active low |
| tx_busy | input | 1 | Transmitter is shifting a character |
| tx_en | output | 1 | Transmitter enable |
| irq | output | 1 | Masked change interrupt |

## Verification
A flag being set by a detected change and all flags being cleared by a status read can fall on the same clock edge. The bench provokes this by toggling DCD and then placing a status read so that it ends on the third edge after the toggle. The first read must show the new level with the flag still clear. A second read must then show the DCD flag set. The other overlap the bench provokes is CTS rising while the transmitter reports busy: tx_en must hold high for the whole busy period and drop one edge after busy falls.

// File: rtl/modem_ctrl_pkg.sv
package modem_ctrl_pkg;
  localparam int unsigned NUM_LINES = 4;

  typedef enum logic [1:0] {
    ADR_CMD  = 2'd0,
    ADR_MODE = 2'd1,
    ADR_STAT = 2'd2,
    ADR_MASK = 2'd3
  } reg_addr_e;

  localparam int unsigned CMD_DTR_ON  = 0;
  localparam int unsigned CMD_DTR_OFF = 1;
  localparam int unsigned CMD_TX_ON   = 2;
  localparam int unsigned CMD_TX_OFF  = 3;

  localparam int unsigned LINE_CTS = 0;
  localparam int unsigned LINE_DSR = 1;
  localparam int unsigned LINE_DCD = 2;
  localparam int unsigned LINE_RI  = 3;
endpackage

// File: rtl/modem_sync.sv
module modem_sync #(
  parameter int unsigned N      = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] async_in,
  output logic [N-1:0] level,
  output logic [N-1:0] toggled
);
  logic [STAGES-1:0][N-1:0] chain;
  logic [N-1:0]             last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain <= '1;
      last  <= '1;
    end else begin
      chain[0] <= async_in;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
      last <= chain[STAGES-1];
    end
  end

  assign level   = chain[STAGES-1];
  assign toggled = level ^ last;
endmodule

// File: rtl/modem_status.sv
module modem_status #(
  parameter int unsigned N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         enable,
  input  logic [N-1:0] toggled,
  input  logic         rd_clear,
  input  logic         mask_wr,
  input  logic [N-1:0] mask_wdata,
  output logic [N-1:0] flags,
  output logic [N-1:0] mask,
  output logic         irq
);
  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_line
      logic flag_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag_q <= 1'b0;
        else        flag_q <= (enable & toggled[g]) | (flag_q & ~rd_clear);
      end
      assign flags[g] = flag_q;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask <= '0;
    else if (mask_wr) mask <= mask_wdata;
  end

  assign irq = |(flags & mask);
endmodule

// File: rtl/modem_lines.sv
module modem_lines (
  input  logic clk,
  input  logic rst_n,
  input  logic modem_on,
  input  logic cmd_wr,
  input  logic dtr_on,
  input  logic dtr_off,
  input  logic tx_on,
  input  logic tx_off,
  input  logic cts_lvl,
  input  logic tx_busy,
  output logic dtr_q,
  output logic sw_tx_q,
  output logic dtr_out,
  output logic rts_out,
  output logic tx_en
);
  logic tx_allow;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dtr_q   <= 1'b1;
      sw_tx_q <= 1'b0;
    end else if (cmd_wr) begin
      if (dtr_off)     dtr_q <= 1'b1;
      else if (dtr_on) dtr_q <= 1'b0;
      if (tx_off)      sw_tx_q <= 1'b0;
      else if (tx_on)  sw_tx_q <= 1'b1;
    end
  end

  assign tx_allow = sw_tx_q & (~modem_on | ~cts_lvl);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tx_en <= 1'b0;
    else        tx_en <= tx_allow | (tx_en & tx_busy & sw_tx_q);
  end

  assign dtr_out = modem_on ? dtr_q : 1'b1;
  assign rts_out = ~(modem_on & sw_tx_q);
endmodule

// File: rtl/modem_ctrl.sv
module modem_ctrl #(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned MODE_W      = 2,
  parameter int unsigned MODEM_CODE  = 3,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        reg_addr,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              cts_in,
  input  logic              dsr_in,
  input  logic              dcd_in,
  input  logic              ri_in,
  output logic              dtr_out,
  output logic              rts_out,
  input  logic              tx_busy,
  output logic              tx_en,
  output logic              irq
);
  import modem_ctrl_pkg::*;
  localparam int unsigned NL = NUM_LINES;

  logic [MODE_W-1:0] mode_q;
  logic              modem_on;
  logic [NL-1:0]     levels, toggled, flags, mask;
  logic              cmd_wr, mode_wr, mask_wr, rd_clear;
  logic              dtr_q, sw_tx_q;
  logic              unused_wdata_hi;

  assign cmd_wr   = reg_wr & (reg_addr == ADR_CMD);
  assign mode_wr  = reg_wr & (reg_addr == ADR_MODE);
  assign mask_wr  = reg_wr & (reg_addr == ADR_MASK);
  assign rd_clear = reg_rd & (reg_addr == ADR_STAT);
  assign unused_wdata_hi = ^reg_wdata[DATA_W-1:NL];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mode_q <= '0;
    else if (mode_wr) mode_q <= reg_wdata[MODE_W-1:0];
  end

  assign modem_on = (mode_q == MODE_W'(MODEM_CODE));

  modem_sync #(.N(NL), .STAGES(SYNC_STAGES)) i_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in ({ri_in, dcd_in, dsr_in, cts_in}),
    .level    (levels),
    .toggled  (toggled)
  );

  modem_status #(.N(NL)) i_status (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (modem_on),
    .toggled    (toggled),
    .rd_clear   (rd_clear),
    .mask_wr    (mask_wr),
    .mask_wdata (reg_wdata[NL-1:0]),
    .flags      (flags),
    .mask       (mask),
    .irq        (irq)
  );

  modem_lines i_lines (
    .clk      (clk),
    .rst_n    (rst_n),
    .modem_on (modem_on),
    .cmd_wr   (cmd_wr),
    .dtr_on   (reg_wdata[CMD_DTR_ON]),
    .dtr_off  (reg_wdata[CMD_DTR_OFF]),
    .tx_on    (reg_wdata[CMD_TX_ON]),
    .tx_off   (reg_wdata[CMD_TX_OFF]),
    .cts_lvl  (levels[LINE_CTS]),
    .tx_busy  (tx_busy),
    .dtr_q    (dtr_q),
    .sw_tx_q  (sw_tx_q),
    .dtr_out  (dtr_out),
    .rts_out  (rts_out),
    .tx_en    (tx_en)
  );

  always_comb begin
    case (reg_addr)
      ADR_MODE: reg_rdata = DATA_W'(mode_q);
      ADR_STAT: reg_rdata = DATA_W'({levels, flags});
      ADR_MASK: reg_rdata = DATA_W'(mask);
      default:  reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/modem_ctrl_chk.sv
module modem_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       modem_on,
  input logic       cmd_wr,
  input logic [3:0] cmd_bits,
  input logic       dtr_q,
  input logic       sw_tx_q,
  input logic       dtr_out,
  input logic       rts_out,
  input logic       tx_en,
  input logic       tx_busy,
  input logic       cts_lvl,
  input logic [3:0] toggled,
  input logic [3:0] flags,
  input logic [3:0] mask,
  input logic       rd_clear,
  input logic       irq
);
  assert_dtr_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !modem_on |-> dtr_out);
  assert_rts_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !modem_on |-> rts_out);
  assert_noflag_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!modem_on && flags == 4'd0) |=> flags == 4'd0);
  assert_dtr_off_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && cmd_bits[1]) |=> dtr_q);
  assert_tx_off_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && cmd_bits[3]) |=> (!sw_tx_q && rts_out));
  assert_flag_src_R5: assert property (@(posedge clk) disable iff (!rst_n)
    toggled == 4'd0 |=> (flags & ~$past(flags)) == 4'd0);
  assert_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clear && toggled == 4'd0) |=> flags == 4'd0);
  assert_irq_masked_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mask == 4'd0 |-> !irq);
  assert_tx_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_en && tx_busy && sw_tx_q) |=> tx_en);
  assert_cts_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (modem_on && cts_lvl && !tx_busy) |=> !tx_en);
endmodule

bind modem_ctrl modem_ctrl_chk i_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .modem_on (modem_on),
  .cmd_wr   (cmd_wr),
  .cmd_bits (reg_wdata[3:0]),
  .dtr_q    (dtr_q),
  .sw_tx_q  (sw_tx_q),
  .dtr_out  (dtr_out),
  .rts_out  (rts_out),
  .tx_en    (tx_en),
  .tx_busy  (tx_busy),
  .cts_lvl  (levels[0]),
  .toggled  (toggled),
  .flags    (flags),
  .mask     (mask),
  .rd_clear (rd_clear),
  .irq      (irq)
);

// File: tb/test_modem_ctrl.sv
module test_modem_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic       reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0] reg_wdata = 8'd0;
  logic [7:0] reg_rdata;
  logic [3:0] lines = 4'hF;
  logic       dtr_out, rts_out, tx_en, irq;
  logic       tx_busy = 1'b0;

  int total = 0, fails = 0;
  logic [3:0] exp_flags = 4'd0, exp_mask = 4'd0;
  logic       exp_modem = 1'b0;
  logic [7:0] rv;

  always #10 clk = ~clk;

  modem_ctrl i_modem_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .cts_in(lines[0]), .dsr_in(lines[1]), .dcd_in(lines[2]), .ri_in(lines[3]),
    .dtr_out(dtr_out), .rts_out(rts_out), .tx_busy(tx_busy), .tx_en(tx_en),
    .irq(irq)
  );

  function automatic logic [7:0] exp_status();
    return {lines, exp_flags};
  endfunction

  function automatic logic exp_irq();
    return |(exp_flags & exp_mask);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = 8'd0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_rd = 1'b1;
    #2 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic rd_status(input string tag);
    logic [7:0] d;
    rd(2'd2, d);
    chk(tag, d, exp_status());
    exp_flags = 4'd0;
  endtask

  task automatic drive_lines(input logic [3:0] v);
    @(negedge clk);
    if (exp_modem) exp_flags = exp_flags | (lines ^ v);
    lines = v;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 dtr_out", dtr_out, 1);
    chk("R1 rts_out", rts_out, 1);
    chk("R1 tx_en", tx_en, 0);
    chk("R1 irq", irq, 0);
    rd(2'd1, rv); chk("R1 mode", rv, 8'h00);
    rd(2'd3, rv); chk("R1 mask", rv, 8'h00);
    rd(2'd2, rv); chk("R1 status", rv, 8'hF0);

    // R2 outside modem mode: no flags, lines stay high
    drive_lines(4'b1101);
    rd_status("R2 no flag outside modem");
    wr(2'd0, 8'h01);
    @(negedge clk);
    chk("R2 dtr_out stays high", dtr_out, 1);
    // R9 tx follows software enable outside modem mode, even with CTS high
    drive_lines(4'b1111);
    wr(2'd0, 8'h04);
    repeat (2) @(negedge clk);
    chk("R9 tx_en free outside modem", tx_en, 1);
    chk("R2 rts_out stays high", rts_out, 1);
    wr(2'd0, 8'h08);
    repeat (2) @(negedge clk);
    chk("R9 tx_en off", tx_en, 0);

    // enter modem mode
    wr(2'd1, 8'h03);
    exp_modem = 1'b1;
    rd(2'd1, rv); chk("R9 mode readback", rv, 8'h03);
    repeat (2) @(negedge clk);
    rd_status("R2 no stale flag on entry");

    // R3 DTR commands (held low from earlier on-command)
    chk("R3 held level", dtr_out, 0);
    wr(2'd0, 8'h02); chk("R3 disable", dtr_out, 1);
    wr(2'd0, 8'h01); chk("R3 enable", dtr_out, 0);
    wr(2'd0, 8'h03); chk("R3 both -> disable", dtr_out, 1);
    wr(2'd0, 8'h01); repeat (3) @(negedge clk);
    chk("R3 held", dtr_out, 0);

    // R4 RTS
    wr(2'd0, 8'h04); chk("R4 rts low", rts_out, 0);
    wr(2'd0, 8'h0C); chk("R4 both -> off", rts_out, 1);

    // R8 CTS gating and hold while busy
    drive_lines(4'b1110);
    wr(2'd0, 8'h04);
    repeat (2) @(negedge clk);
    chk("R8 tx_en with cts low", tx_en, 1);
    @(negedge clk);
    tx_busy = 1'b1;
    drive_lines(4'b1111);
    repeat (3) @(negedge clk);
    chk("R8 hold while busy", tx_en, 1);
    tx_busy = 1'b0;
    @(negedge clk);
    chk("R8 drop after busy", tx_en, 0);
    drive_lines(4'b1110);
    chk("R8 re-enable", tx_en, 1);
    drive_lines(4'b1111);
    chk("R8 cts high idle", tx_en, 0);
    wr(2'd0, 8'h08);
    rd_status("R5 cts flag from gating run");

    // R6 set and read clear on the same edge
    @(negedge clk);
    lines = 4'b1011;
    @(negedge clk);
    rd(2'd2, rv);
    chk("R6 first read", rv, 8'hB0);
    rd(2'd2, rv);
    chk("R6 flag survives clear", rv, 8'hB4);

    // R5 both directions
    drive_lines(4'b1111);
    rd_status("R5 rising edge dcd");
    drive_lines(4'b0111);
    rd_status("R5 falling edge ri");
    rd_status("R6 cleared after read");

    // R7 mask
    drive_lines(4'b0101);
    chk("R7 all masked", irq, 0);
    wr(2'd3, 8'h02); exp_mask = 4'h2;
    @(negedge clk);
    chk("R7 dsr unmasked", irq, 1);
    wr(2'd3, 8'h01); exp_mask = 4'h1;
    @(negedge clk);
    chk("R7 cts only", irq, 0);

    // random mix
    for (int it = 0; it < 400; it++) begin
      int op;
      op = $urandom % 4;
      if (op < 2) begin
        logic [3:0] t;
        t = 4'($urandom);
        drive_lines(lines ^ t);
        chk("R7 irq random", irq, exp_irq());
      end else if (op == 2) begin
        rd_status("R5 status random");
        @(negedge clk);
        chk("R6 irq after clear", irq, 0);
      end else begin
        logic [3:0] m;
        m = 4'($urandom);
        wr(2'd3, {4'd0, m}); exp_mask = m;
        @(negedge clk);
        chk("R7 irq after mask", irq, exp_irq());
      end
    end

    // R2 leaving modem mode
    wr(2'd1, 8'h01);
    exp_modem = 1'b0;
    @(negedge clk);
    chk("R2 dtr high after exit", dtr_out, 1);
    rd(2'd1, rv); chk("R9 mode readback 1", rv, 8'h01);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule